// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block moves one device-side transfer buffer to or from system memory by following a table of region descriptors that software has placed in memory. Each descriptor is an 8-byte record: the low 32-bit word is the physical start address of a memory region, and the high word holds the region byte count together with an end-of-table flag. The walker fetches one descriptor, then issues memory bursts against that region until either the region or the device buffer runs out. It then fetches the next descriptor. It stops when the buffer is empty, when the flagged final descriptor is used up, or when it has read one full page of descriptors without finding the flag.

Every memory access is a single command on a valid/ready master port. The command carries an address, a byte length, a write flag, a descriptor-fetch flag, and the offset into the device buffer where the burst starts. Descriptor contents return on a separate 64-bit response channel. The data path that moves the burst bytes is outside this block. A `restart` pulse loads the descriptor pointer from the table base. A `start` pulse begins a new buffer transfer and continues from the current pointer.

Top module: `sgdma_walker`

## Requirements
- R1: After reset the walker is idle. `busy`, `mem_valid`, `done` and `eot` are all low, and no request is raised while idle.
- R2: A descriptor fetch is a request with `mem_fetch`=1, `mem_len`=8 and `mem_addr` equal to the descriptor pointer. The pointer then advances by 8. On the response, `rsp_data[31:0]` is the region address and `rsp_data[63:32]` is the size/flag word.
- R3: The region byte count is size-word bits 15:1 with bit 0 forced to zero, so an odd size is rounded down.
- R4: A decoded count of zero means 65536 bytes. No data burst is ever 0 bytes long or longer than 65536 bytes.
- R5: Size-word bit 31 marks the final descriptor. Once that region is used up with buffer bytes still left, `eot` pulses for one cycle and no further fetch is made.
- R6: If the pointer has moved TABLE_SPAN or more bytes past the table base and the current region is empty, `eot` pulses and the walk ends without another fetch. TABLE_SPAN is 4096 by default.
- R7: Each data burst covers the smaller of the bytes left in the buffer and the bytes left in the region. `mem_buf_off` gives the buffer offset of the burst. The region address and count both move by the burst length. A new descriptor is fetched only when the region count is zero.
- R8: `mem_write` is 1 on data bursts when `dir`=1 (device to memory) and 0 when `dir`=0 (memory to device). It is always 0 on descriptor fetches.
- R9: When the buffer empties, `done` pulses for exactly one cycle and the walker returns to idle. `done` and `eot` are never high together.
- R10: `start` clears the current region address, region count and final flag, so the first step of a new transfer is always a fetch. The pointer continues from where it stopped. `restart` reloads the pointer and the base from `table_base`.
- R11: A request held with `mem_ready` low keeps `mem_valid`, `mem_addr`, `mem_len` and `mem_fetch` unchanged until it is accepted.
- R12: `start` and `restart` have no effect while `busy` is high.
- R13: A transfer started with `buf_len`=0 raises `done` without any memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer of `buf_len` bytes in direction `dir` |
| restart | input | 1 | Load the descriptor pointer and base from `table_base` |
| dir | input | 1 | 1: device to memory (memory write), 0: memory to device |
| table_base | input | AW | Descriptor table base address |
| buf_len | input | LEN_W | Device buffer length in bytes |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_fetch | output | 1 | Request is a descriptor fetch |
| mem_write | output | 1 | Request writes memory |
| mem_addr | output | AW | Request byte address |
| mem_len | output | 17 | Request byte length |
| mem_buf_off | output | LEN_W | Device buffer offset of the burst |
| rsp_valid | input | 1 | Descriptor data valid |
| rsp_data | input | 64 | Descriptor contents, address word in bits 31:0 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: buffer exhausted |
| eot | output | 1 | One-cycle pulse: descriptors ran out first |

## Verification
The bench builds the walker with TABLE_SPAN=64, so the page fail-safe trips after eight unflagged descriptors rather than 512. That keeps the fail-safe case within a short run. LEN_W is 18, which lets the buffer exceed a full 65536-byte region, so the zero-size decode can be seen as one maximal burst followed by end-of-table. Memory readiness and response latency follow a pseudo-random pattern, so stalls land on both fetches and data bursts.

// File: rtl/sgdma_walker.sv
module sgdma_walker #(
  parameter int AW         = 32,
  parameter int LEN_W      = 24,
  parameter int TABLE_SPAN = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             restart,
  input  logic             dir,
  input  logic [AW-1:0]    table_base,
  input  logic [LEN_W-1:0] buf_len,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_fetch,
  output logic             mem_write,
  output logic [AW-1:0]    mem_addr,
  output logic [16:0]      mem_len,
  output logic [LEN_W-1:0] mem_buf_off,
  input  logic             rsp_valid,
  input  logic [63:0]      rsp_data,
  output logic             busy,
  output logic             done,
  output logic             eot
);
  localparam int CW = (LEN_W > 17) ? LEN_W : 17;
  localparam logic [AW-1:0] SPAN = AW'(TABLE_SPAN);
  localparam logic [AW-1:0] DSTEP = AW'(8);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_FREQ, S_FWAIT, S_XFER} st_t;
  st_t st;

  logic [AW-1:0]    ptr, base, raddr;
  logic [16:0]      cnt;
  logic             last, we;
  logic [LEN_W-1:0] len_q, off;

  wire              buf_empty = (off == len_q);
  wire              span_hit  = (ptr - base) >= SPAN;
  wire [CW-1:0]     rem_w     = CW'(len_q - off);
  wire [CW-1:0]     cnt_w     = CW'(cnt);
  wire [16:0]       burst     = (rem_w > cnt_w) ? cnt : rem_w[16:0];
  wire [15:0]       sz_even   = {rsp_data[47:33], 1'b0};
  wire [16:0]       cnt_dec   = (sz_even == 16'd0) ? 17'h10000 : {1'b0, sz_even};

  assign busy        = (st != S_IDLE);
  assign done        = (st == S_CHECK) && buf_empty;
  assign eot         = (st == S_CHECK) && !buf_empty && (cnt == 17'd0) && (last || span_hit);
  assign mem_valid   = (st == S_FREQ) || (st == S_XFER);
  assign mem_fetch   = (st == S_FREQ);
  assign mem_write   = (st == S_XFER) && we;
  assign mem_addr    = (st == S_FREQ) ? ptr : raddr;
  assign mem_len     = (st == S_FREQ) ? 17'd8 : burst;
  assign mem_buf_off = off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr   <= '0;
      base  <= '0;
      raddr <= '0;
      cnt   <= '0;
      last  <= 1'b0;
      we    <= 1'b0;
      len_q <= '0;
      off   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (restart) begin
            ptr  <= table_base;
            base <= table_base;
          end
          if (start) begin
            len_q <= buf_len;
            off   <= '0;
            we    <= dir;
            raddr <= '0;
            cnt   <= '0;
            last  <= 1'b0;
            st    <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (buf_empty)                 st <= S_IDLE;
          else if (cnt != 17'd0)         st <= S_XFER;
          else if (last || span_hit)     st <= S_IDLE;
          else                           st <= S_FREQ;
        end
        S_FREQ: if (mem_ready) begin
          ptr <= ptr + DSTEP;
          st  <= S_FWAIT;
        end
        S_FWAIT: if (rsp_valid) begin
          raddr <= AW'(rsp_data[31:0]);
          cnt   <= cnt_dec;
          last  <= rsp_data[63];
          st    <= S_CHECK;
        end
        S_XFER: if (mem_ready) begin
          raddr <= raddr + AW'(burst);
          cnt   <= cnt - burst;
          off   <= off + LEN_W'(burst);
          st    <= S_CHECK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_walker_chk.sv
module sgdma_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          eot,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_fetch,
  input logic [AW-1:0] mem_addr,
  input logic [16:0]   mem_len
);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  assert_fetch_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_fetch |-> mem_len == 17'd8);

  assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_fetch |-> (mem_len != 17'd0) && (mem_len <= 17'h10000));

  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !eot);

  assert_finish_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done || eot |=> !busy);

  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_len) && $stable(mem_fetch));
endmodule

bind sgdma_walker sgdma_walker_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .eot(eot),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_fetch(mem_fetch),
  .mem_addr(mem_addr), .mem_len(mem_len)
);

// File: tb/test_sgdma_walker.sv
module test_sgdma_walker;
  localparam int LW = 18;
  localparam int SPAN = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0, restart = 1'b0, dir = 1'b0;
  logic [31:0]   table_base = '0;
  logic [LW-1:0] buf_len = '0;
  logic          mem_valid, mem_fetch, mem_write, busy, done, eot;
  logic          mem_ready = 1'b0, rsp_valid = 1'b0;
  logic [31:0]   mem_addr;
  logic [16:0]   mem_len;
  logic [LW-1:0] mem_buf_off;
  logic [63:0]   rsp_data = '0;

  sgdma_walker #(.AW(32), .LEN_W(LW), .TABLE_SPAN(SPAN)) i_sgdma_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .restart(restart), .dir(dir),
    .table_base(table_base), .buf_len(buf_len), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_fetch(mem_fetch), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_buf_off(mem_buf_off),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .done(done), .eot(eot)
  );

  typedef struct packed {
    logic          fetch;
    logic          we;
    logic [31:0]   addr;
    logic [16:0]   len;
    logic [LW-1:0] off;
  } item_t;

  item_t       q[$];
  int          checks = 0, fails = 0, n_done = 0, n_eot = 0;
  logic [63:0] tbl [128];
  logic [31:0] m_ptr = '0, m_base = '0;
  logic [7:0]  lfsr = 8'hA5;
  logic        pend = 1'b0, stalled = 1'b0;
  logic [1:0]  dly = '0;
  logic [63:0] pend_data = '0;
  logic [31:0] st_addr = '0;
  logic [16:0] st_len = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) n_done++;
      if (eot) n_eot++;
      rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 2'd0) begin
          rsp_valid = 1'b1;
          rsp_data  = pend_data;
          pend      = 1'b0;
        end else dly = dly - 2'd1;
      end
      if (stalled) begin
        check(mem_valid && mem_addr == st_addr && mem_len == st_len, "R11",
              "held request", mem_addr, st_addr);
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = lfsr[0] | lfsr[3];
      stalled = mem_valid && !mem_ready;
      st_addr = mem_addr;
      st_len  = mem_len;
      if (mem_valid && mem_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R7", "unexpected request", mem_addr, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(mem_fetch == it.fetch, it.fetch ? "R2" : "R7", "kind", mem_fetch, it.fetch);
          check(mem_addr == it.addr, it.fetch ? "R2" : "R7", "address", mem_addr, it.addr);
          check(mem_len == it.len, it.fetch ? "R2" : "R7", "length", mem_len, it.len);
          check(mem_write == it.we, "R8", "write flag", mem_write, it.we);
          if (!it.fetch) check(mem_buf_off == it.off, "R7", "buffer offset", mem_buf_off, it.off);
        end
        if (mem_fetch) begin
          pend      = 1'b1;
          dly       = lfsr[2:1];
          pend_data = tbl[mem_addr[9:3]];
        end
      end
    end
  end

  task automatic do_restart(input logic [31:0] b);
    @(negedge clk);
    table_base = b;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    m_ptr = b;
    m_base = b;
  endtask

  task automatic run(input logic [LW-1:0] len, input bit d, input bit poke, input string req);
    int unsigned off = 0, cnt = 0, b;
    logic [31:0] ra = '0;
    bit lst = 1'b0, exp_eot;
    item_t it;
    forever begin
      if (off == len) begin exp_eot = 1'b0; break; end
      if (cnt == 0) begin
        if (lst || (m_ptr - m_base) >= SPAN) begin exp_eot = 1'b1; break; end
        it = '{fetch: 1'b1, we: 1'b0, addr: m_ptr, len: 17'd8, off: '0};
        q.push_back(it);
        ra  = tbl[m_ptr[9:3]][31:0];
        cnt = tbl[m_ptr[9:3]][47:32] & 16'hfffe;
        if (cnt == 0) cnt = 65536;
        lst = tbl[m_ptr[9:3]][63];
        m_ptr = m_ptr + 8;
      end else begin
        b = (len - off < cnt) ? len - off : cnt;
        it = '{fetch: 1'b0, we: d, addr: ra, len: 17'(b), off: LW'(off)};
        q.push_back(it);
        ra = ra + b; cnt = cnt - b; off = off + b;
      end
    end
    @(negedge clk);
    n_done = 0; n_eot = 0;
    buf_len = len; dir = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; restart = 1'b1; table_base = 32'h300; buf_len = LW'(5); dir = ~d;
      @(negedge clk);
      start = 1'b0; restart = 1'b0;
    end
    while (busy) @(negedge clk);
    check(n_done == (exp_eot ? 0 : 1), req, "done pulses", n_done, exp_eot ? 0 : 1);
    check(n_eot == (exp_eot ? 1 : 0), req, "eot pulses", n_eot, exp_eot ? 1 : 0);
    check(q.size() == 0, req, "pending expected requests", q.size(), 0);
    q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) tbl[i] = '0;
    // fail-safe table at 0x000: eight unflagged 16-byte regions
    for (int i = 0; i < 8; i++) tbl[i] = {32'h0000_0010, 32'h0000_6000 + 32'(i * 32'h100)};
    // main table at 0x100
    tbl[32] = {32'h0000_0100, 32'h0000_1000};
    tbl[33] = {32'h0000_0081, 32'h0000_2000};   // odd size rounds down (R3)
    tbl[34] = {32'h8000_0200, 32'h0000_3000};
    tbl[35] = {32'h8000_0040, 32'h0000_4000};
    // zero size with final flag at 0x200 (R4)
    tbl[64] = {32'h8000_0000, 32'h0001_0000};
    // exact-fit final region at 0x300
    tbl[96] = {32'h8000_0020, 32'h0000_5000};

    repeat (4) @(negedge clk);
    check(!busy && !mem_valid && !done && !eot, "R1", "reset state",
          {busy, mem_valid, done, eot}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_valid, "R1", "idle after reset", {busy, mem_valid}, 0);

    // R2 R3 R7 R8 R12: three regions, buffer-limited final burst, ignored pokes
    do_restart(32'h100);
    run(LW'(18'h300), 1'b1, 1'b1, "R12");
    // R10: new start keeps pointer, drops leftover region and final flag
    run(LW'(18'h40), 1'b0, 1'b0, "R10");
    // R4 R5: 65536-byte region then end of table
    do_restart(32'h200);
    run(LW'(18'h18000), 1'b1, 1'b0, "R5");
    // R6: page fail-safe after SPAN bytes of descriptors
    do_restart(32'h000);
    run(LW'(18'h1000), 1'b0, 1'b0, "R6");
    // R9: buffer ends exactly with the final region
    do_restart(32'h300);
    run(LW'(18'h20), 1'b1, 1'b0, "R9");
    // R13: zero-length buffer
    do_restart(32'h100);
    run(LW'(0), 1'b1, 1'b0, "R13");
    // R10: restart reloads the pointer
    do_restart(32'h300);
    run(LW'(18'h10), 1'b0, 1'b0, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule